// File: doc/BRIEF.md
# DCO Frequency Correction Controller

This block steers the 20-bit tuning word of a digitally controlled oscillator onto a target channel frequency. It does not use a reference-locked loop. An external measurement path returns one signed frequency error, in hertz, each time the block asks for one. The block adds a correction to the tuning word and writes the new word to the oscillator as a serial SPI frame. It then asks for the next error. This measure-and-write cycle repeats until the error is inside the lock window.

A channel change loads a new target offset. It forces one coarse correction, derived from a stored estimate of the coarse step size. After that first update, every correction moves only the fine code. When the fine code would leave its range, the correction spills into the medium code. If lock is not reached within a bounded number of writes, the run ends with a fail flag. After any run ends, a recalibration timer starts a new fine-only run, so that the block tracks slow drift.

Top module: `freq_corr_ctrl`

## Requirements
- R1: After reset the tuning word is coarse 32, medium 32, fine 128. `locked`, `fail`, `meas_req`, `spi_sclk` and `tgt_off_khz` are 0, and `spi_cs_n` is 1.
- R2: A `chan_req` sampled while the block is idle has three effects on the next cycle: `tgt_off_khz` becomes `chan_idx` × 300, `locked` and `fail` clear, and `meas_req` pulses for one cycle.
- R3: The first correction after a channel request changes only the coarse code. The new coarse code is coarse + round(err / 450000), with round-half-away-from-zero, clamped to 0..63.
- R4: Every other correction changes only the fine code, to fine + round(err / 590), rounded half away from zero.
- R5: If that fine result exceeds 255, fine becomes 128 and medium goes up by one. If the result is below 0, fine becomes 128 and medium goes down by one. Medium is clamped to 0..63.
- R6: An error with |err| < 1000 Hz sets `locked`, returns the block to idle and causes no SPI write.
- R7: Each correction sends exactly one 24-bit SPI frame, MSB first: address 4'h3, then coarse[5:0], medium[5:0], fine[7:0]. `spi_cs_n` is low for the whole frame and `spi_sclk` idles low. The oscillator samples data on the rising edge (mode 0).
- R8: After each frame ends, `meas_req` pulses once while `spi_cs_n` is high. Only then does the block accept the next error.
- R9: If the error that arrives after 16 writes in a run is still outside the lock window, the block sets `fail`, clears `locked`, writes nothing and returns to idle.
- R10: When the block has been idle for RECAL_CYC cycles since the end of a run (with at least one channel request since reset), it pulses `meas_req` and starts a fine-only run without any `chan_req`.
- R11: A `chan_req` that arrives while a run is in progress is ignored, and `tgt_off_khz` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_req | input | 1 | Channel change request (one cycle) |
| chan_idx | input | CHAN_W | Requested channel number |
| err_valid | input | 1 | Measured error is valid this cycle |
| err_hz | input | ERR_W | Signed error: measured minus target, in Hz |
| meas_req | output | 1 | Request for one error measurement |
| tgt_off_khz | output | OFF_W | Target offset from the band base, in kHz |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI serial data |
| locked | output | 1 | The last completed run reached lock |
| fail | output | 1 | The last completed run hit the write limit |

## Verification
Two outcomes are hard to reach from the ports: a run that exhausts all 16 writes, and the coarse code clamping at zero. A well-behaved oscillator converges in a handful of cycles and never gets near either one. The bench therefore gives its oscillator model two extra settings. One is a stuck mode, in which the model returns a constant error whatever the codes; with a steady 50 kHz error the fine code carries into the medium code several times before the fail limit is reached. The other is a large negative drift offset, which drives the coarse estimate below zero so the clamp takes effect. The recalibration path is reached by changing the drift after a lock and counting idle cycles until the next measurement request.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int CODE_C_W = 6;
  localparam int CODE_M_W = 6;
  localparam int CODE_F_W = 8;
  localparam int TUNE_W   = CODE_C_W + CODE_M_W + CODE_F_W;
  localparam int ADDR_W   = 4;
  localparam int FRAME_W  = ADDR_W + TUNE_W;

  localparam int C_MAX = (1 << CODE_C_W) - 1;
  localparam int M_MAX = (1 << CODE_M_W) - 1;
  localparam int F_MAX = (1 << CODE_F_W) - 1;
  localparam int C_MID = 1 << (CODE_C_W - 1);
  localparam int M_MID = 1 << (CODE_M_W - 1);
  localparam int F_MID = 1 << (CODE_F_W - 1);

  typedef struct packed {
    logic [CODE_C_W-1:0] c;
    logic [CODE_M_W-1:0] m;
    logic [CODE_F_W-1:0] f;
  } tune_t;

  typedef enum logic [1:0] {S_IDLE, S_MEAS, S_WRITE} seq_state_e;

  function automatic int abs_i(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // quotient rounded to nearest, halves away from zero
  function automatic int div_round(input int num, input int den);
    int q;
    q = (abs_i(num) + den / 2) / den;
    return (num < 0) ? -q : q;
  endfunction

  function automatic int clamp(input int v, input int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/fcc_spi.sv
module fcc_spi #(
  parameter int FRAME_BITS = 24,
  parameter int HALF_DIV   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  mosi,
  output logic                  done
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_BITS);

  logic                  active;
  logic [DIV_W-1:0]      div;
  logic [BIT_W-1:0]      bits;
  logic [FRAME_BITS-1:0] sh;
  logic                  half_tick;

  assign half_tick = (div == DIV_W'(HALF_DIV - 1));
  assign mosi      = !cs_n && sh[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cs_n   <= 1'b1;
      sclk   <= 1'b0;
      sh     <= '0;
      bits   <= '0;
      div    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          cs_n   <= 1'b0;
          sh     <= frame;
          bits   <= '0;
          div    <= '0;
          sclk   <= 1'b0;
        end
      end else if (half_tick) begin
        div <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (bits == BIT_W'(FRAME_BITS - 1)) begin
            active <= 1'b0;
            cs_n   <= 1'b1;
            done   <= 1'b1;
          end else begin
            bits <= bits + 1'b1;
            sh   <= {sh[FRAME_BITS-2:0], 1'b0};
          end
        end
      end else begin
        div <= div + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fcc_recal.sv
module fcc_recal #(
  parameter int RECAL_CYC = 12_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic hold,
  output logic tick
);
  localparam int CNT_W = (RECAL_CYC > 1) ? $clog2(RECAL_CYC) : 1;

  logic             armed;
  logic [CNT_W-1:0] cnt;

  assign tick = armed && !hold && (cnt == CNT_W'(RECAL_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else begin
      if (arm) armed <= 1'b1;
      if (hold || !armed || tick) cnt <= '0;
      else                        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
  import fcc_pkg::*;
#(
  parameter int CHAN_W         = 4,
  parameter int OFF_W          = 13,
  parameter int ERR_W          = 24,
  parameter int SPACING_KHZ    = 300,
  parameter int COARSE_STEP_HZ = 450_000,
  parameter int FINE_STEP_HZ   = 590,
  parameter int LOCK_HZ        = 1000,
  parameter int MAX_ITER       = 16,
  parameter int IT_W           = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_chan,
  input  logic [CHAN_W-1:0]       chan_idx,
  input  logic                    start_recal,
  input  logic                    err_valid,
  input  logic signed [ERR_W-1:0] err_hz,
  input  logic                    spi_done,
  output tune_t                   tw,
  output logic                    spi_start,
  output logic                    meas_req,
  output logic                    locked,
  output logic                    fail,
  output logic [OFF_W-1:0]        tgt_off_khz,
  output logic                    busy,
  output logic                    upd_coarse,
  output logic                    fail_hit,
  output logic [IT_W-1:0]         iter
);
  seq_state_e st;
  logic       coarse_ph;
  logic       in_win, at_limit, take;
  int         err_i, f_sum;
  tune_t      tw_nxt;

  assign busy       = (st != S_IDLE);
  assign take       = (st == S_MEAS) && err_valid;
  assign in_win     = abs_i(err_i) < LOCK_HZ;
  assign at_limit   = (iter == IT_W'(MAX_ITER));
  assign upd_coarse = take && !in_win && !at_limit && coarse_ph;
  assign fail_hit   = take && !in_win && at_limit;

  always_comb begin
    err_i  = int'(err_hz);
    tw_nxt = tw;
    f_sum  = int'(tw.f) + div_round(err_i, FINE_STEP_HZ);
    if (coarse_ph) begin
      tw_nxt.c = CODE_C_W'(clamp(int'(tw.c) + div_round(err_i, COARSE_STEP_HZ), C_MAX));
    end else if (f_sum > F_MAX) begin
      tw_nxt.f = CODE_F_W'(F_MID);
      tw_nxt.m = CODE_M_W'(clamp(int'(tw.m) + 1, M_MAX));
    end else if (f_sum < 0) begin
      tw_nxt.f = CODE_F_W'(F_MID);
      tw_nxt.m = CODE_M_W'(clamp(int'(tw.m) - 1, M_MAX));
    end else begin
      tw_nxt.f = CODE_F_W'(f_sum);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      tw          <= '{c: CODE_C_W'(C_MID), m: CODE_M_W'(M_MID), f: CODE_F_W'(F_MID)};
      coarse_ph   <= 1'b0;
      iter        <= '0;
      locked      <= 1'b0;
      fail        <= 1'b0;
      meas_req    <= 1'b0;
      spi_start   <= 1'b0;
      tgt_off_khz <= '0;
    end else begin
      meas_req  <= 1'b0;
      spi_start <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_chan) begin
            tgt_off_khz <= OFF_W'(int'(chan_idx) * SPACING_KHZ);
            coarse_ph   <= 1'b1;
            iter        <= '0;
            locked      <= 1'b0;
            fail        <= 1'b0;
            meas_req    <= 1'b1;
            st          <= S_MEAS;
          end else if (start_recal) begin
            coarse_ph <= 1'b0;
            iter      <= '0;
            meas_req  <= 1'b1;
            st        <= S_MEAS;
          end
        end
        S_MEAS: begin
          if (take) begin
            if (in_win) begin
              locked <= 1'b1;
              fail   <= 1'b0;
              st     <= S_IDLE;
            end else if (at_limit) begin
              fail   <= 1'b1;
              locked <= 1'b0;
              st     <= S_IDLE;
            end else begin
              tw        <= tw_nxt;
              iter      <= iter + 1'b1;
              coarse_ph <= 1'b0;
              spi_start <= 1'b1;
              st        <= S_WRITE;
            end
          end
        end
        S_WRITE: begin
          if (spi_done) begin
            meas_req <= 1'b1;
            st       <= S_MEAS;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/freq_corr_ctrl.sv
module freq_corr_ctrl
  import fcc_pkg::*;
#(
  parameter int CHAN_W         = 4,
  parameter int ERR_W          = 24,
  parameter int SPACING_KHZ    = 300,
  parameter int COARSE_STEP_HZ = 450_000,
  parameter int FINE_STEP_HZ   = 590,
  parameter int LOCK_HZ        = 1000,
  parameter int MAX_ITER       = 16,
  parameter int RECAL_CYC      = 12_500_000,
  parameter int SCLK_HALF      = 2,
  parameter int TUNE_ADDR      = 3,
  localparam int OFF_W         = $clog2(((1 << CHAN_W) - 1) * SPACING_KHZ + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    chan_req,
  input  logic [CHAN_W-1:0]       chan_idx,
  input  logic                    err_valid,
  input  logic signed [ERR_W-1:0] err_hz,
  output logic                    meas_req,
  output logic [OFF_W-1:0]        tgt_off_khz,
  output logic                    spi_sclk,
  output logic                    spi_cs_n,
  output logic                    spi_mosi,
  output logic                    locked,
  output logic                    fail
);
  localparam int IT_W = $clog2(MAX_ITER + 1);

  tune_t             tw;
  logic              spi_start, spi_done, busy, recal_tick;
  logic              upd_coarse, fail_hit;
  logic [IT_W-1:0]   iter;
  logic [TUNE_W-1:0] tune_word;
  logic [FRAME_W-1:0] frame;

  assign tune_word = tw;
  assign frame     = {ADDR_W'(TUNE_ADDR), tune_word};

  fcc_seq #(
    .CHAN_W(CHAN_W), .OFF_W(OFF_W), .ERR_W(ERR_W), .SPACING_KHZ(SPACING_KHZ),
    .COARSE_STEP_HZ(COARSE_STEP_HZ), .FINE_STEP_HZ(FINE_STEP_HZ),
    .LOCK_HZ(LOCK_HZ), .MAX_ITER(MAX_ITER), .IT_W(IT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_chan(chan_req), .chan_idx(chan_idx),
    .start_recal(recal_tick), .err_valid(err_valid), .err_hz(err_hz),
    .spi_done(spi_done), .tw(tw), .spi_start(spi_start), .meas_req(meas_req),
    .locked(locked), .fail(fail), .tgt_off_khz(tgt_off_khz), .busy(busy),
    .upd_coarse(upd_coarse), .fail_hit(fail_hit), .iter(iter)
  );

  fcc_spi #(.FRAME_BITS(FRAME_W), .HALF_DIV(SCLK_HALF)) u_spi (
    .clk(clk), .rst_n(rst_n), .start(spi_start), .frame(frame),
    .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .done(spi_done)
  );

  fcc_recal #(.RECAL_CYC(RECAL_CYC)) u_recal (
    .clk(clk), .rst_n(rst_n), .arm(chan_req), .hold(busy), .tick(recal_tick)
  );
endmodule

// File: rtl/fcc_chk.sv
module fcc_chk #(
  parameter int OFF_W    = 13,
  parameter int IT_W     = 5,
  parameter int TW_W     = 20,
  parameter int MAX_ITER = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_req,
  input logic             busy,
  input logic [OFF_W-1:0] tgt_off_khz,
  input logic             spi_cs_n,
  input logic             spi_sclk,
  input logic             meas_req,
  input logic             locked,
  input logic             fail,
  input logic             upd_coarse,
  input logic             fail_hit,
  input logic [IT_W-1:0]  iter,
  input logic [TW_W-1:0]  tune_word
);
  p_sclk_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  p_coarse_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_coarse |=> tune_word[TW_W-7:0] == $past(tune_word[TW_W-7:0]));

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && fail));

  p_fail_at_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_hit |-> iter == IT_W'(MAX_ITER));

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && chan_req) |=> $stable(tgt_off_khz));

  p_meas_after_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req |-> spi_cs_n);

  p_lock_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> spi_cs_n);
endmodule

bind freq_corr_ctrl fcc_chk #(
  .OFF_W(OFF_W), .IT_W(IT_W), .TW_W(fcc_pkg::TUNE_W), .MAX_ITER(MAX_ITER)
) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .busy(busy),
  .tgt_off_khz(tgt_off_khz), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
  .meas_req(meas_req), .locked(locked), .fail(fail), .upd_coarse(upd_coarse),
  .fail_hit(fail_hit), .iter(iter), .tune_word(tune_word)
);

// File: tb/tb_freq_corr_ctrl.sv
module tb_freq_corr_ctrl;
  localparam int RECAL = 300;
  localparam int EW    = 26;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 chan_req = 1'b0;
  logic [3:0]           chan_idx = '0;
  logic                 err_valid = 1'b0;
  logic signed [EW-1:0] err_hz = '0;
  logic                 meas_req, spi_sclk, spi_cs_n, spi_mosi, locked, fail;
  logic [12:0]          tgt_off_khz;

  freq_corr_ctrl #(.ERR_W(EW), .RECAL_CYC(RECAL)) dut (
    .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .chan_idx(chan_idx),
    .err_valid(err_valid), .err_hz(err_hz), .meas_req(meas_req),
    .tgt_off_khz(tgt_off_khz), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .locked(locked), .fail(fail)
  );

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int mc = 32, mm = 32, mf = 128;
  int chan_m = 0, drift = 0, stuck_err = 0;
  bit stuck = 0, mon_en = 0, started = 0;
  int exp_tgt = 0, exp_locked = 0, exp_fail = 0;
  logic [23:0] frame_q[$];

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int osc_err();
    if (stuck) return stuck_err;
    return (32 - mc) * 450000 + (32 - mm) * 151040 + (128 - mf) * 590
           + drift - chan_m * 300000;
  endfunction

  function automatic int rq(input int e, input int s);
    real q;
    q = real'(e) / real'(s);
    if (q >= 0.0) return int'($floor(q + 0.5));
    return -int'($floor(-q + 0.5));
  endfunction

  function automatic int lim(input int v, input int hi);
    return (v < 0) ? 0 : ((v > hi) ? hi : v);
  endfunction

  // per-clock comparison of the flags and the target against the model
  always @(posedge clk) begin
    #2;
    if (mon_en) begin
      check("R2/R6/R9", "locked", int'(locked), exp_locked);
      check("R9", "fail", int'(fail), exp_fail);
      check("R2/R11", "tgt_off_khz", int'(tgt_off_khz), exp_tgt);
    end
  end

  logic [23:0] shf;
  int nb;
  always @(negedge spi_cs_n) begin shf = '0; nb = 0; end
  always @(posedge spi_sclk) if (!spi_cs_n) begin shf = {shf[22:0], spi_mosi}; nb++; end
  always @(posedge spi_cs_n) if (started) begin
    if (frame_q.size() == 0) begin
      check("R6", "unexpected frame", 1, 0);
    end else begin
      logic [23:0] ef;
      ef = frame_q.pop_front();
      check("R7", "frame bits", nb, 24);
      check("R3/R4/R5/R7", "frame", int'(shf), int'(ef));
    end
  end

  task automatic wait_meas(output int k);
    k = 0;
    do begin
      @(negedge clk);
      chan_req = 1'b0;
      k++;
    end while (!meas_req && k < RECAL + 400);
    if (!meas_req) check("R8/R10", "meas_req timeout", 0, 1);
  endtask

  task automatic new_chan(input int ch);
    @(negedge clk);
    chan_req = 1'b1;
    chan_idx = 4'(ch);
    chan_m = ch;
    exp_tgt = ch * 300;
    exp_locked = 0;
    exp_fail = 0;
  endtask

  // one correction run; poke drives a chan_req while busy (R11)
  task automatic run(input bit coarse_first, input bit poke, output int first_wait);
    bit ph;
    int it, k, e;
    bit done;
    ph = coarse_first; it = 0; done = 0; first_wait = -1;
    while (!done) begin
      wait_meas(k);
      if (first_wait < 0) first_wait = k;
      if (!meas_req) return;
      e = osc_err();
      err_valid = 1'b1;
      err_hz = EW'(e);
      if (e > -1000 && e < 1000) begin
        exp_locked = 1; exp_fail = 0; done = 1;
      end else if (it == 16) begin
        exp_fail = 1; exp_locked = 0; done = 1;
      end else begin
        if (ph) mc = lim(mc + rq(e, 450000), 63);
        else if (mf + rq(e, 590) > 255) begin mf = 128; mm = lim(mm + 1, 63); end
        else if (mf + rq(e, 590) < 0)   begin mf = 128; mm = lim(mm - 1, 63); end
        else mf = mf + rq(e, 590);
        frame_q.push_back({4'h3, 6'(mc), 6'(mm), 8'(mf)});
        it++; ph = 0;
        if (poke && it == 1) begin chan_req = 1'b1; chan_idx = 4'd2; end
      end
      @(negedge clk);
      err_valid = 1'b0;
      chan_req = 1'b0;
    end
    check("R6/R7", "frames pending at run end", frame_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    started = 1; mon_en = 1;
    // R1 reset state
    check("R1", "locked", int'(locked), 0);
    check("R1", "fail", int'(fail), 0);
    check("R1", "cs_n", int'(spi_cs_n), 1);
    check("R1", "sclk", int'(spi_sclk), 0);
    check("R1", "meas_req", int'(meas_req), 0);
    check("R1", "tgt", int'(tgt_off_khz), 0);

    // channel 5: coarse step, then fine with a borrow
    new_chan(5);
    run(1, 0, w);
    check("R6", "locked after ch5", int'(locked), 1);

    // recalibration after drift, fine only
    drift = 20000;
    run(0, 0, w);
    check("R10", "idle cycles before recal", w, RECAL);
    check("R6", "locked after recal", int'(locked), 1);

    // channel 12 with a request poked while busy
    new_chan(12);
    run(1, 1, w);
    check("R11", "tgt kept", int'(tgt_off_khz), 12 * 300);
    check("R6", "locked after ch12", int'(locked), 1);

    // stuck oscillator: fine carries and the write limit
    stuck = 1; stuck_err = 50000;
    new_chan(3);
    run(1, 0, w);
    check("R9", "fail set", int'(fail), 1);
    check("R9", "locked clear", int'(locked), 0);
    stuck = 0;

    // large negative drift: coarse clamps at zero
    drift = -16000000;
    new_chan(0);
    run(1, 0, w);
    check("R3", "coarse clamped", mc, 0);

    // back to a sane channel
    drift = 0;
    new_chan(6);
    run(1, 0, w);
    check("R6", "final lock state", int'(locked), exp_locked);
    check("R2", "final tgt", int'(tgt_off_khz), 1800);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule